// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Tracker

This block watches the command pins of a four-bank SDRAM interface. On every rising clock edge it samples chip select, row strobe, column strobe, write enable, the bank address and the auto-precharge address bit. It turns each sampled cycle into a command code. A checker or controller-side monitor uses it to see which banks are open and whether each Activate, Precharge and Write obeys the timing rules.

Each bank has an open flag and a precharge timer. The timer is a down-counter that is loaded whenever the bank closes. One tracker follows the most recent read or write burst. From it the block judges whether a Precharge arrives early enough to cut the burst short. For writes with auto-precharge it works out when the bank closes by itself, or when a later command forces that close.

Every result is registered. The results for a command sampled at edge N are on the outputs after edge N and stay there until edge N+1. The pins form a plain command bus with no valid/ready handshake, so the block never applies back-pressure. Burst length, CAS latency, the precharge time and the write-recovery time are parameters.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` low, the pins {`ras_n`,`cas_n`,`we_n`} decode onto `cmd_o` as follows: 111→0 (idle), 011→1 (activate), 101→2 (read), 100→3 (write), 010→4 (precharge) and 110→5 (burst stop). Every other pattern gives 6 (other). The code appears one cycle after the sampling edge.
- R2: While `cs_n` is high, `cmd_o` shows 0 whatever the other pins hold, and no bank state changes.
- R3: An activate to a closed bank whose timer has expired opens it: bit `ba` of `bank_open_o` becomes 1.
- R4: A precharge with `a10` low closes only bank `ba`. With `a10` high it closes every open bank.
- R5: Closing a bank starts its timer. An activate to that bank at fewer than T_RP cycles after the closing edge, or to a bank that is already open, raises `act_viol_o` for exactly one cycle and leaves the bank as it was. At exactly T_RP cycles the activate is accepted.
- R6: A write to a closed bank raises `act_viol_o`'s sibling `wr_viol_o` for one cycle and does not open the bank.
- R7: A precharge that hits the bank of the current read burst at an offset below BURST_LEN−CAS_LAT cycles from the read raises `pre_viol_o`. At that offset or later it does not.
- R8: A precharge that hits the bank of the current write burst at an offset below BURST_LEN−1+T_DPL cycles from the write raises `pre_viol_o`. At that offset or later it does not.
- R9: A write with `a10` high closes its bank by itself at offset BURST_LEN−1+T_DPL. An activate to that bank is accepted no earlier than T_RP cycles after that point.
- R10: A pending auto-precharge write closes its bank at once when any precharge, a burst stop, or a read or write to another bank is sampled.
- R11: Idle and deselected cycles do not end a pending burst. The bank of an auto-precharge write stays open until its scheduled close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | All-banks / auto-precharge select |
| cmd_o | output | 3 | Decoded command code (see R1) |
| bank_open_o | output | 4 | One open flag per bank |
| act_viol_o | output | 1 | Illegal activate pulse |
| pre_viol_o | output | 1 | Early precharge (burst cut) pulse |
| wr_viol_o | output | 1 | Write to closed bank pulse |

## Verification
Every output comes from one register stage. The code, the flags and the bank state for a command sampled at a rising edge are therefore due one cycle later. The bench drives the pins on the falling edge and reads the results on the next falling edge, which is half a cycle after the sampling edge. Burst-window and timer cases are counted in sampling edges from the command that opened the burst or closed the bank. Each check issues its command at the offset named in its requirement, both one edge before the limit and at the limit, and reads the result in the following half cycle.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_BST   = 3'd5,
    CMD_OTHER = 3'd6
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_IDLE;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_IDLE;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_DPL     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  cmd_e                         cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic                         a10,
  input  logic [NUM_BANKS-1:0]         bank_open,
  output logic                         pre_early,
  output logic                         wr_bad,
  output logic                         ap_fire,
  output logic [$clog2(NUM_BANKS)-1:0] ap_bank
);
  localparam int BA_W   = $clog2(NUM_BANKS);
  localparam int WR_WIN = BURST_LEN - 1 + T_DPL;
  localparam int RD_WIN = (BURST_LEN > CAS_LAT) ? BURST_LEN - CAS_LAT : 0;
  localparam int AW     = $clog2(WR_WIN + 2);

  logic            live_q, wr_q, ap_q;
  logic [BA_W-1:0] bank_q;
  logic [AW-1:0]   age_q, win_q;

  logic is_pre, is_bst, is_rd, is_wr, wr_ok, col_new, in_win, pre_on_burst, expired;

  assign is_pre  = (cmd == CMD_PRE);
  assign is_bst  = (cmd == CMD_BST);
  assign is_rd   = (cmd == CMD_RD);
  assign is_wr   = (cmd == CMD_WR);
  assign wr_bad  = is_wr && !bank_open[ba];
  assign wr_ok   = is_wr && bank_open[ba];
  assign col_new = is_rd || wr_ok;

  assign expired      = age_q >= win_q;
  assign in_win       = live_q && !expired;
  assign pre_on_burst = is_pre && (a10 || (ba == bank_q));
  assign pre_early    = in_win && pre_on_burst;
  assign ap_fire      = live_q && wr_q && ap_q &&
                        (expired || is_pre || is_bst || (col_new && (ba != bank_q)));
  assign ap_bank      = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      age_q  <= '0;
      win_q  <= '0;
    end else if (col_new) begin
      live_q <= 1'b1;
      wr_q   <= is_wr;
      ap_q   <= is_wr && a10;
      bank_q <= ba;
      age_q  <= AW'(1);
      win_q  <= is_wr ? AW'(WR_WIN) : AW'(RD_WIN);
    end else if (live_q && (expired || is_bst || pre_on_burst || ap_fire)) begin
      live_q <= 1'b0;
    end else if (live_q) begin
      age_q <= age_q + 1'b1;
    end
  end

  // R8
  age_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && win_q != '0) |-> (age_q <= win_q));

  // R7
  burst_start_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_new |=> (live_q && age_q == AW'(1)));
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int T_RP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic close_req,
  output logic open_o,
  output logic act_bad_o
);
  localparam int            CW     = $clog2(T_RP + 1);
  localparam logic [CW-1:0] RELOAD = CW'(T_RP - 1);

  logic          open_q, act_bad_q;
  logic [CW-1:0] cnt_q;
  logic          busy, act_bad, closing;

  assign busy    = (cnt_q != '0);
  assign act_bad = act_hit && (open_q || busy);
  assign closing = close_req && open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cnt_q     <= '0;
      act_bad_q <= 1'b0;
    end else begin
      act_bad_q <= act_bad;
      if (closing) begin
        open_q <= 1'b0;
        cnt_q  <= RELOAD;
      end else begin
        if (act_hit && !act_bad) open_q <= 1'b1;
        if (busy) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign open_o    = open_q;
  assign act_bad_o = act_bad_q;

  // R3
  open_timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt_q == '0));

  // R5
  close_loads_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> (cnt_q == RELOAD));

  // R5
  refused_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_bad_q |-> !$rose(open_q));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 3,
  parameter int T_DPL     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic                         a10,
  output logic [2:0]                   cmd_o,
  output logic [NUM_BANKS-1:0]         bank_open_o,
  output logic                         act_viol_o,
  output logic                         pre_viol_o,
  output logic                         wr_viol_o
);
  localparam int BA_W = $clog2(NUM_BANKS);

  cmd_e                 dec_cmd, cmd_q;
  logic [NUM_BANKS-1:0] open_vec, act_bad_vec;
  logic                 pre_early, wr_bad, ap_fire;
  logic [BA_W-1:0]      ap_bank;
  logic                 pre_viol_q, wr_viol_q;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (dec_cmd)
  );

  sdram_burst_track #(
    .NUM_BANKS(NUM_BANKS),
    .BURST_LEN(BURST_LEN),
    .CAS_LAT  (CAS_LAT),
    .T_DPL    (T_DPL)
  ) u_brst (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (dec_cmd),
    .ba       (ba),
    .a10      (a10),
    .bank_open(open_vec),
    .pre_early(pre_early),
    .wr_bad   (wr_bad),
    .ap_fire  (ap_fire),
    .ap_bank  (ap_bank)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic act_hit, close_req;
    assign act_hit   = (dec_cmd == CMD_ACT) && (ba == BA_W'(g));
    assign close_req = ((dec_cmd == CMD_PRE) && (a10 || (ba == BA_W'(g)))) ||
                       (ap_fire && (ap_bank == BA_W'(g)));
    sdram_bank_slot #(.T_RP(T_RP)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_hit  (act_hit),
      .close_req(close_req),
      .open_o   (open_vec[g]),
      .act_bad_o(act_bad_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= CMD_IDLE;
      pre_viol_q <= 1'b0;
      wr_viol_q  <= 1'b0;
    end else begin
      cmd_q      <= dec_cmd;
      pre_viol_q <= pre_early;
      wr_viol_q  <= wr_bad;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_open_o = open_vec;
  assign act_viol_o  = |act_bad_vec;
  assign pre_viol_o  = pre_viol_q;
  assign wr_viol_o   = wr_viol_q;

  // R2
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (cmd_o == 3'd0));

  // R6
  viol_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({act_viol_o, pre_viol_o, wr_viol_o}) <= 1);
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;
  localparam int NB    = 4;
  localparam int BL    = 4;
  localparam int CL    = 2;
  localparam int TRP   = 3;
  localparam int TDPL  = 2;
  localparam int WRW   = BL - 1 + TDPL;
  localparam int RDW   = BL - CL;
  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101,
                         P_WR = 3'b100, P_PRE = 3'b010, P_BST = 3'b110,
                         P_REF = 3'b001, P_MRS = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [2:0] cmd_o;
  logic [NB-1:0] bank_open_o;
  logic act_viol_o, pre_viol_o, wr_viol_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .BURST_LEN(BL), .CAS_LAT(CL),
                      .T_RP(TRP), .T_DPL(TDPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
    .act_viol_o(act_viol_o), .pre_viol_o(pre_viol_o), .wr_viol_o(wr_viol_o));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge, after the sampling edge.
  task automatic drive(input logic cs, input logic [2:0] rcw, input int b, input logic ap);
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); a10 = ap;
    @(negedge clk);
  endtask

  task automatic nop();
    drive(1'b0, P_NOP, 0, 1'b0);
  endtask

  task automatic settle();
    drive(1'b0, P_PRE, 0, 1'b1);
    repeat (TRP) nop();
  endtask

  task automatic t_decode();
    nop();                          chk("R1 idle code", cmd_o, 0);
    drive(1'b0, P_REF, 0, 1'b0);    chk("R1 refresh->other", cmd_o, 6);
    drive(1'b0, P_MRS, 0, 1'b0);    chk("R1 mode->other", cmd_o, 6);
    drive(1'b0, P_BST, 0, 1'b0);    chk("R1 burst stop code", cmd_o, 5);
    drive(1'b0, P_PRE, 0, 1'b0);    chk("R1 precharge code", cmd_o, 4);
    drive(1'b0, P_ACT, 1, 1'b0);    chk("R1 activate code", cmd_o, 1);
    drive(1'b0, P_WR, 1, 1'b0);     chk("R1 write code", cmd_o, 3);
    drive(1'b0, P_RD, 1, 1'b0);     chk("R1 read code", cmd_o, 2);
    settle();
  endtask

  task automatic t_deselect();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b1, P_PRE, 0, 1'b1);
    chk("R2 deselect code", cmd_o, 0);
    chk("R2 deselected precharge no close", bank_open_o, 4'b0001);
    drive(1'b1, P_ACT, 2, 1'b0);
    chk("R2 deselected activate no open", bank_open_o, 4'b0001);
    chk("R2 deselect no violation", act_viol_o, 0);
    settle();
  endtask

  task automatic t_open_close();
    drive(1'b0, P_ACT, 0, 1'b0);    chk("R3 open bank0", bank_open_o, 4'b0001);
    drive(1'b0, P_ACT, 1, 1'b0);    chk("R3 open bank1", bank_open_o, 4'b0011);
    drive(1'b0, P_ACT, 2, 1'b0);    chk("R3 open bank2", bank_open_o, 4'b0111);
    drive(1'b0, P_PRE, 1, 1'b0);    chk("R4 single close", bank_open_o, 4'b0101);
    drive(1'b0, P_PRE, 3, 1'b1);    chk("R4 all close", bank_open_o, 4'b0000);
    repeat (TRP) nop();
  endtask

  task automatic t_act_timing();
    drive(1'b0, P_ACT, 3, 1'b0);
    drive(1'b0, P_ACT, 3, 1'b0);    chk("R5 activate open bank", act_viol_o, 1);
    nop();                          chk("R5 one-cycle pulse", act_viol_o, 0);
    drive(1'b0, P_PRE, 3, 1'b0);
    for (int k = 1; k <= TRP; k++) begin
      drive(1'b0, P_ACT, 3, 1'b0);
      chk($sformatf("R5 activate at offset %0d flag", k), act_viol_o, (k < TRP) ? 1 : 0);
      chk($sformatf("R5 activate at offset %0d state", k), bank_open_o[3], (k == TRP) ? 1 : 0);
    end
    settle();
  endtask

  task automatic t_wr_closed();
    drive(1'b0, P_WR, 2, 1'b0);
    chk("R6 write closed flag", wr_viol_o, 1);
    chk("R6 write closed bank stays shut", bank_open_o, 4'b0000);
    nop();                          chk("R6 pulse ends", wr_viol_o, 0);
  endtask

  task automatic t_rd_window();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b0, P_RD, 0, 1'b0);
    for (int k = 1; k < RDW - 1; k++) nop();
    drive(1'b0, P_PRE, 0, 1'b0);    chk("R7 early read precharge", pre_viol_o, 1);
    settle();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b0, P_RD, 0, 1'b0);
    for (int k = 1; k < RDW; k++) drive(1'b1, P_NOP, 0, 1'b0);
    drive(1'b0, P_PRE, 0, 1'b0);
    chk("R7 read precharge at limit", pre_viol_o, 0);
    chk("R7 bank closed", bank_open_o[0], 0);
    settle();
  endtask

  task automatic t_wr_window();
    drive(1'b0, P_ACT, 1, 1'b0);
    drive(1'b0, P_WR, 1, 1'b0);
    for (int k = 1; k < WRW - 1; k++) nop();
    drive(1'b0, P_PRE, 1, 1'b0);    chk("R8 early write precharge", pre_viol_o, 1);
    settle();
    drive(1'b0, P_ACT, 1, 1'b0);
    drive(1'b0, P_WR, 1, 1'b0);
    for (int k = 1; k < WRW; k++) nop();
    drive(1'b0, P_PRE, 1, 1'b0);    chk("R8 write precharge at limit", pre_viol_o, 0);
    settle();
  endtask

  task automatic t_wr_ap();
    drive(1'b0, P_ACT, 2, 1'b0);
    drive(1'b0, P_WR, 2, 1'b1);
    for (int k = 1; k < WRW; k++) drive(logic'(k % 2), P_NOP, 0, 1'b0);
    chk("R11 idle cycles keep bank open", bank_open_o[2], 1);
    nop();                          chk("R9 auto close at window end", bank_open_o[2], 0);
    for (int k = 1; k < TRP - 1; k++) nop();
    drive(1'b0, P_ACT, 2, 1'b0);    chk("R9 activate before recovery", act_viol_o, 1);
    drive(1'b0, P_ACT, 2, 1'b0);    chk("R9 activate after recovery", act_viol_o, 0);
    chk("R9 bank reopened", bank_open_o[2], 1);
    settle();
  endtask

  task automatic t_ap_cut();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b0, P_ACT, 1, 1'b0);
    drive(1'b0, P_WR, 0, 1'b1);
    drive(1'b0, P_RD, 1, 1'b0);     chk("R10 read other bank closes", bank_open_o, 4'b0010);
    drive(1'b0, P_ACT, 0, 1'b0);    chk("R10 timer started", act_viol_o, 1);
    settle();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b0, P_WR, 0, 1'b1);
    drive(1'b0, P_BST, 0, 1'b0);    chk("R10 burst stop closes", bank_open_o, 4'b0000);
    settle();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b0, P_WR, 0, 1'b1);
    drive(1'b0, P_PRE, 3, 1'b0);    chk("R10 precharge elsewhere closes", bank_open_o, 4'b0000);
    settle();
    drive(1'b0, P_ACT, 0, 1'b0);
    drive(1'b0, P_ACT, 1, 1'b0);
    drive(1'b0, P_WR, 0, 1'b1);
    drive(1'b0, P_WR, 1, 1'b0);     chk("R10 write other bank closes", bank_open_o, 4'b0010);
    settle();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("reset code", cmd_o, 0);
    chk("reset banks", bank_open_o, 0);
    chk("reset flags", {act_viol_o, pre_viol_o, wr_viol_o}, 0);
    t_decode();
    t_deselect();
    t_open_close();
    t_act_timing();
    t_wr_closed();
    t_rd_window();
    t_wr_window();
    t_wr_ap();
    t_ap_cut();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule